// File: doc/BRIEF.md
# Physical Register Busy Table

This block tracks, for every physical register of an out-of-order core, whether its value has been produced yet. One state bit per register says busy (a producer is in flight) or ready. Rename lanes set a register busy when they hand it out as a new destination. Replay requests also set a register busy when an instruction must run again. Writeback ports clear the bit once a result with a destination lands. Issue logic presents register-file read addresses on query ports and gets a ready bit back for each one in the same cycle.

A writeback in the current cycle is forwarded to the query answers at once, so a consumer does not lose a cycle waiting for the state register. A flush, raised on an exception or a pipeline-flush redirect, returns every register to ready. Register 0 is the hardwired zero register and is always ready. The numbers of registers, query ports, writeback ports, allocation lanes and replay ports are all parameters. An integer instance would use as many query ports as integer reads plus memory reads.

Top module: `preg_busy_table`

## Requirements
- R1: After reset every query port returns ready (1) for every register address.
- R2: A valid allocation for register p (p != 0) with no flush makes p read busy (0) from the next cycle on, until a writeback or flush clears it.
- R3: A valid writeback for register p clears its busy bit, so p reads ready in the following cycles.
- R4: A valid replay for register p (p != 0) with no flush makes p read busy from the next cycle.
- R5: When the same register receives an allocation or replay and a writeback in one cycle, it is busy in the next cycle.
- R6: A flush makes every register ready in the next cycle, overriding any allocation or replay in that cycle.
- R7: A query whose address equals the register of a valid writeback in the same cycle returns ready in that cycle, whatever the stored state.
- R8: Register 0 always reads ready; an allocation or replay naming register 0 has no effect.
- R9: Each query port answers independently from the state stored at the last clock edge: ready is 1 when the register is not busy, and 0 when it is busy and no bypass applies. Port k uses bits [k*PREG_W +: PREG_W] of the packed address and port vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Clear all busy state |
| alloc_valid | input | NUM_ALLOC | Per rename lane: allocation present |
| alloc_preg | input | NUM_ALLOC*PREG_W | Per lane: allocated register |
| replay_valid | input | NUM_REPLAY | Per replay port: request present |
| replay_preg | input | NUM_REPLAY*PREG_W | Per replay port: register to set busy |
| wb_valid | input | NUM_WB | Per writeback port: result with destination |
| wb_preg | input | NUM_WB*PREG_W | Per writeback port: destination register |
| query_addr | input | NUM_QUERY*PREG_W | Per query port: register address |
| query_ready | output | NUM_QUERY | Per query port: ready bit |

## Verification
The two functions that collide are marking a register busy (allocation or replay) and marking it ready (writeback), which can name the same register in one cycle, while a query may also hit that writeback. The bench forces this with directed cycles on a single register and with random traffic confined to a small address window so collisions recur. A bench model judges both the same-cycle query answer, which must show the bypassed ready, and the next-cycle answer, which must show busy.

// File: rtl/preg_busy_pkg.sv
package preg_busy_pkg;
    // Width of an index into n entries, never below one bit.
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/preg_set_decode.sv
module preg_set_decode #(
    parameter int NUM_PORTS = 2,
    parameter int NUM_PREGS = 64,
    parameter int PREG_W    = 6
) (
    input  logic [NUM_PORTS-1:0]        req_valid,
    input  logic [NUM_PORTS*PREG_W-1:0] req_preg,
    output logic [NUM_PREGS-1:0]        mask
);
    always_comb begin
        mask = '0;
        for (int k = 0; k < NUM_PORTS; k++) begin
            if (req_valid[k]) begin
                mask[req_preg[k*PREG_W +: PREG_W]] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/preg_ready_query.sv
module preg_ready_query #(
    parameter int NUM_QUERY = 4,
    parameter int NUM_WB    = 4,
    parameter int NUM_PREGS = 64,
    parameter int PREG_W    = 6
) (
    input  logic [NUM_PREGS-1:0]        busy_q,
    input  logic [NUM_QUERY*PREG_W-1:0] query_addr,
    input  logic [NUM_WB-1:0]           wb_valid,
    input  logic [NUM_WB*PREG_W-1:0]    wb_preg,
    output logic [NUM_QUERY-1:0]        query_ready
);
    for (genvar q = 0; q < NUM_QUERY; q++) begin : g_port
        logic [PREG_W-1:0] addr;
        logic              bypass;
        assign addr = query_addr[q*PREG_W +: PREG_W];
        always_comb begin
            bypass = 1'b0;
            for (int w = 0; w < NUM_WB; w++) begin
                if (wb_valid[w] && (wb_preg[w*PREG_W +: PREG_W] == addr)) begin
                    bypass = 1'b1;
                end
            end
        end
        assign query_ready[q] = (addr == '0) || !busy_q[addr] || bypass;
    end
endmodule

// File: rtl/preg_busy_table.sv
module preg_busy_table #(
    parameter int NUM_PREGS  = 64,
    parameter int NUM_QUERY  = 4,
    parameter int NUM_WB     = 4,
    parameter int NUM_ALLOC  = 2,
    parameter int NUM_REPLAY = 2,
    localparam int PREG_W    = preg_busy_pkg::idx_w(NUM_PREGS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic [NUM_ALLOC-1:0]         alloc_valid,
    input  logic [NUM_ALLOC*PREG_W-1:0]  alloc_preg,
    input  logic [NUM_REPLAY-1:0]        replay_valid,
    input  logic [NUM_REPLAY*PREG_W-1:0] replay_preg,
    input  logic [NUM_WB-1:0]            wb_valid,
    input  logic [NUM_WB*PREG_W-1:0]     wb_preg,
    input  logic [NUM_QUERY*PREG_W-1:0]  query_addr,
    output logic [NUM_QUERY-1:0]         query_ready
);
    typedef struct packed {
        logic [NUM_PREGS-1:0] busy;
    } state_t;

    state_t state_d, state_q;

    logic [NUM_PREGS-1:0] alloc_mask, replay_mask, wb_mask;

    preg_set_decode #(.NUM_PORTS(NUM_ALLOC), .NUM_PREGS(NUM_PREGS), .PREG_W(PREG_W)) u_alloc_dec (
        .req_valid(alloc_valid), .req_preg(alloc_preg), .mask(alloc_mask)
    );
    preg_set_decode #(.NUM_PORTS(NUM_REPLAY), .NUM_PREGS(NUM_PREGS), .PREG_W(PREG_W)) u_replay_dec (
        .req_valid(replay_valid), .req_preg(replay_preg), .mask(replay_mask)
    );
    preg_set_decode #(.NUM_PORTS(NUM_WB), .NUM_PREGS(NUM_PREGS), .PREG_W(PREG_W)) u_wb_dec (
        .req_valid(wb_valid), .req_preg(wb_preg), .mask(wb_mask)
    );

    // Next state: flush clears, set-busy beats set-ready, entry 0 pinned ready.
    always_comb begin
        state_d = state_q;
        if (flush) begin
            state_d.busy = '0;
        end else begin
            state_d.busy = (state_q.busy & ~wb_mask) | alloc_mask | replay_mask;
        end
        state_d.busy[0] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    preg_ready_query #(
        .NUM_QUERY(NUM_QUERY), .NUM_WB(NUM_WB), .NUM_PREGS(NUM_PREGS), .PREG_W(PREG_W)
    ) u_query (
        .busy_q(state_q.busy), .query_addr(query_addr), .wb_valid(wb_valid),
        .wb_preg(wb_preg), .query_ready(query_ready)
    );
endmodule

// File: rtl/preg_busy_table_chk.sv
module preg_busy_table_chk #(
    parameter int NUM_PREGS  = 64,
    parameter int NUM_QUERY  = 4,
    parameter int NUM_WB     = 4,
    parameter int NUM_ALLOC  = 2,
    parameter int NUM_REPLAY = 2,
    parameter int PREG_W     = 6
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         flush,
    input logic [NUM_ALLOC-1:0]         alloc_valid,
    input logic [NUM_ALLOC*PREG_W-1:0]  alloc_preg,
    input logic [NUM_REPLAY-1:0]        replay_valid,
    input logic [NUM_REPLAY*PREG_W-1:0] replay_preg,
    input logic [NUM_WB-1:0]            wb_valid,
    input logic [NUM_WB*PREG_W-1:0]     wb_preg,
    input logic [NUM_QUERY*PREG_W-1:0]  query_addr,
    input logic [NUM_QUERY-1:0]         query_ready,
    input logic [NUM_PREGS-1:0]         busy_q
);
    for (genvar q = 0; q < NUM_QUERY; q++) begin : g_q
        p_zero_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (query_addr[q*PREG_W +: PREG_W] == '0) |-> query_ready[q]);
    end

    p_wb_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid[0] && (query_addr[0 +: PREG_W] == wb_preg[0 +: PREG_W])) |-> query_ready[0]);

    p_alloc_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid[0] && !flush && (alloc_preg[0 +: PREG_W] != '0))
        |=> busy_q[$past(alloc_preg[0 +: PREG_W])]);

    p_replay_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (replay_valid[0] && !flush && (replay_preg[0 +: PREG_W] != '0))
        |=> busy_q[$past(replay_preg[0 +: PREG_W])]);

    p_flush_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (busy_q == '0));
endmodule

bind preg_busy_table preg_busy_table_chk #(
    .NUM_PREGS(NUM_PREGS), .NUM_QUERY(NUM_QUERY), .NUM_WB(NUM_WB),
    .NUM_ALLOC(NUM_ALLOC), .NUM_REPLAY(NUM_REPLAY), .PREG_W(PREG_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .alloc_valid(alloc_valid), .alloc_preg(alloc_preg),
    .replay_valid(replay_valid), .replay_preg(replay_preg),
    .wb_valid(wb_valid), .wb_preg(wb_preg),
    .query_addr(query_addr), .query_ready(query_ready),
    .busy_q(state_q.busy)
);

// File: tb/sim_preg_busy_table.sv
module sim_preg_busy_table;
    localparam int NP = 64, NQ = 4, NW = 4, NA = 2, NR = 2, W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic [NA-1:0]   alloc_valid = '0;
    logic [NA*W-1:0] alloc_preg = '0;
    logic [NR-1:0]   replay_valid = '0;
    logic [NR*W-1:0] replay_preg = '0;
    logic [NW-1:0]   wb_valid = '0;
    logic [NW*W-1:0] wb_preg = '0;
    logic [NQ*W-1:0] query_addr = '0;
    logic [NQ-1:0]   query_ready;

    int total = 0, bad = 0;
    bit done = 0;
    logic [NP-1:0] model = '0;

    always #5 clk = ~clk;

    preg_busy_table u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .alloc_valid(alloc_valid), .alloc_preg(alloc_preg),
        .replay_valid(replay_valid), .replay_preg(replay_preg),
        .wb_valid(wb_valid), .wb_preg(wb_preg),
        .query_addr(query_addr), .query_ready(query_ready)
    );

    function automatic logic exp_ready(input logic [W-1:0] a);
        logic r;
        r = (a == '0) || !model[a];
        for (int w = 0; w < NW; w++)
            if (wb_valid[w] && wb_preg[w*W +: W] == a) r = 1'b1;
        return r;
    endfunction

    function automatic logic [NP-1:0] next_model();
        logic [NP-1:0] m;
        m = model;
        if (flush) m = '0;
        else begin
            for (int w = 0; w < NW; w++) if (wb_valid[w]) m[wb_preg[w*W +: W]] = 1'b0;
            for (int k = 0; k < NA; k++) if (alloc_valid[k]) m[alloc_preg[k*W +: W]] = 1'b1;
            for (int k = 0; k < NR; k++) if (replay_valid[k]) m[replay_preg[k*W +: W]] = 1'b1;
        end
        m[0] = 1'b0;
        return m;
    endfunction

    task automatic check_all(input string tag);
        #1;
        for (int q = 0; q < NQ; q++) begin
            logic e;
            e = exp_ready(query_addr[q*W +: W]);
            total++;
            if (query_ready[q] !== e) begin
                bad++;
                $display("FAIL %s port %0d addr %0d: got %b expected %b", tag, q,
                         query_addr[q*W +: W], query_ready[q], e);
            end
        end
    endtask

    // Check now, then commit the cycle and move to the next falling edge.
    task automatic step(input string tag);
        check_all(tag);
        @(posedge clk);
        model = next_model();
        @(negedge clk);
        flush = 0; alloc_valid = '0; replay_valid = '0; wb_valid = '0;
    endtask

    task automatic query_all(input logic [W-1:0] a);
        for (int q = 0; q < NQ; q++) query_addr[q*W +: W] = a;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unused;
        unused = $urandom(32'd1234);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: all ready after reset
        for (int a = 0; a < NP; a += NQ) begin
            for (int q = 0; q < NQ; q++) query_addr[q*W +: W] = W'(a + q);
            check_all("R1");
        end
        // R2: allocate 5 on lane 1
        alloc_valid = 2'b10; alloc_preg = {W'(5), W'(0)}; query_all(5);
        step("R2 same cycle");
        step("R2 busy");
        // R7: writeback bypass to 5 while stored busy
        wb_valid = 4'b0100; wb_preg = {W'(0), W'(5), W'(0), W'(0)};
        step("R7");
        step("R3");
        // R5: alloc and writeback on 9 together
        alloc_valid = 2'b01; alloc_preg = {W'(0), W'(9)}; query_all(9);
        step("R5 prep");
        alloc_valid = 2'b01; alloc_preg = {W'(0), W'(9)};
        wb_valid = 4'b0001; wb_preg = {W'(0), W'(0), W'(0), W'(9)};
        step("R5 bypass");
        step("R5 busy wins");
        // R4: replay 12
        replay_valid = 2'b10; replay_preg = {W'(12), W'(0)}; query_all(12);
        step("R4 same cycle");
        step("R4 busy");
        // R8: allocate/replay register 0
        alloc_valid = 2'b11; alloc_preg = {W'(0), W'(0)};
        replay_valid = 2'b01; replay_preg = {W'(0), W'(0)}; query_all(0);
        step("R8 same cycle");
        step("R8 still ready");
        // R6: flush with simultaneous allocation
        flush = 1; alloc_valid = 2'b01; alloc_preg = {W'(0), W'(20)};
        for (int q = 0; q < NQ; q++) query_addr[q*W +: W] = W'(q == 0 ? 20 : (q == 1 ? 9 : 12));
        step("R6 same cycle");
        step("R6 cleared");
        // R9 with mixed traffic; small window provokes collisions (R5, R7)
        for (int i = 0; i < 3000; i++) begin
            int win;
            win = (i % 2 == 0) ? 8 : NP;
            flush = ($urandom_range(0, 99) == 0);
            for (int k = 0; k < NA; k++) begin
                alloc_valid[k] = $urandom_range(0, 1);
                alloc_preg[k*W +: W] = W'($urandom_range(0, win - 1));
            end
            for (int k = 0; k < NR; k++) begin
                replay_valid[k] = ($urandom_range(0, 3) == 0);
                replay_preg[k*W +: W] = W'($urandom_range(0, win - 1));
            end
            for (int w = 0; w < NW; w++) begin
                wb_valid[w] = $urandom_range(0, 1);
                wb_preg[w*W +: W] = W'($urandom_range(0, win - 1));
            end
            for (int q = 0; q < NQ; q++) query_addr[q*W +: W] = W'($urandom_range(0, win - 1));
            step("R9 random");
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule